// File: doc/BRIEF.md
# ADC chain conversion sequencer

This block decides which analog channel an attached converter samples next. Software selects channels for two kinds of chain with one mask bit per channel. A normal chain runs once, or keeps repeating when scan mode is on. An injected chain takes priority: if it is requested while a normal chain is running, the normal chain pauses once its current channel has finished. After the injected chain ends, the normal chain carries on from the channel it had not yet converted.

The sequencer sends a start pulse and a channel number to the converter. It waits for the converter's done strobe, then passes that strobe on with the channel index and a chain tag, so that whatever consumes the result knows where to store it. Each chain kind has a one-cycle end-of-chain interrupt. Software can stop the channel now being converted. It can also stop the whole chain. What a chain stop does depends on scan mode and on whether an injected chain is running on top of a paused normal chain.

Top module: `adc_chain_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it, every output is 0. This includes the start bits, the pending abort bits, the pulses and the channel fields.
- R2: Inside a chain, channels are converted from the lowest index upward, and any channel whose mask bit is 0 is skipped. `soc` is only raised while the start bit of the chain named by `soc_inj` is set.
- R3: Each converter done strobe for a channel that was not aborted produces `eoc_out` one cycle later. `eoc_ch` then holds that channel and `eoc_inj` holds the chain tag (0 = normal, 1 = injected).
- R4: With scan off, completing the last selected normal channel raises `norm_irq` in the same cycle as that channel's `eoc_out`, and clears `norm_active`.
- R5: With scan on, completing the last selected normal channel raises `norm_irq` and restarts the chain at its lowest selected channel, and `norm_active` stays 1.
- R6: Starting an injected chain whose mask is all zero, with no other conversion running, raises `inj_irq` within two cycles, issues no `soc`, and clears `inj_active`.
- R7: An injected start that arrives during a normal conversion lets that channel finish, runs the whole injected chain, and then resumes the normal chain at its next selected channel.
- R8: An injected start request made while an injected chain is pending or running has no effect: that chain is converted only once.
- R9: A channel abort request made during a conversion sets `abort_conv_pend` on the following cycle. On the cycle after that, `abort_conv_pend` returns to 0 and `soc` is raised for the next selected channel. The aborted channel produces no `eoc_out`, and the start bit stays set.
- R10: A chain abort with scan off clears `norm_active` and `abort_chain_pend` together. No interrupt is raised and no further channel is converted.
- R11: A chain abort with scan on restarts the normal chain at its lowest selected channel, with no interrupt.
- R12: A chain abort while an injected chain is running over a paused normal chain clears both `inj_active` and `norm_active`, with no interrupt and no further conversion.
- R13: Completing the last selected injected channel raises `inj_irq` in the same cycle as that channel's `eoc_out`, and clears `inj_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | 1 = the normal chain repeats; 0 = it runs once |
| norm_mask | input | NUM_CH | Channel select bits for the normal chain |
| inj_mask | input | NUM_CH | Channel select bits for the injected chain |
| norm_go | input | 1 | One-cycle request to set the normal start bit |
| inj_go | input | 1 | One-cycle request to set the injected start bit |
| abort_conv_req | input | 1 | One-cycle request to abort the current channel |
| abort_chain_req | input | 1 | One-cycle request to abort the current chain |
| conv_done | input | 1 | End-of-conversion strobe from the converter |
| soc | output | 1 | Start-of-conversion pulse to the converter |
| soc_ch | output | $clog2(NUM_CH) | Channel to convert, valid with `soc` |
| soc_inj | output | 1 | Chain tag of the started conversion |
| eoc_out | output | 1 | End-of-conversion strobe for the result path |
| eoc_ch | output | $clog2(NUM_CH) | Channel of the finished conversion |
| eoc_inj | output | 1 | Chain tag of the finished conversion |
| norm_irq | output | 1 | Normal end-of-chain pulse |
| inj_irq | output | 1 | Injected end-of-chain pulse |
| norm_active | output | 1 | Normal start bit |
| inj_active | output | 1 | Injected start bit |
| abort_conv_pend | output | 1 | Channel abort request waiting to be handled |
| abort_chain_pend | output | 1 | Chain abort request waiting to be handled |

## Verification
The hardest case to reach is a chain abort that lands while an injected chain is running and a normal chain is paused under it. Getting there needs three requests in the right order, each timed against the converter's latency. The bench starts a normal chain and waits for its first result strobe. It then raises the injected request while the second normal channel is still converting, waits until the first injected result appears, and only then issues the chain abort. Channel aborts are handled the same way: the bench waits for a known strobe, so it knows which channel is in flight when the abort arrives.

// File: rtl/adc_seq_pkg.sv
// Package adc_seq_pkg
// Holds the types and tag values that the sequencer modules share.
package adc_seq_pkg;

    // Controller state: ST_IDLE picks the next chain, ST_CONV waits on the converter.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_st_e;

    // Chain tag values carried next to the start and done strobes.
    localparam logic TAG_NORM = 1'b0;
    localparam logic TAG_INJ  = 1'b1;

endpackage

// File: rtl/adc_seq_pick.sv
// Module adc_seq_pick
// Finds the lowest set bit of a channel mask whose index is at least `from`.
// It is purely combinational. `from` is one bit wider than a channel index,
// so "one past the last channel" can be expressed, and then nothing is found.
module adc_seq_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CH_W:0]     from,
    output logic              found,
    output logic [CH_W-1:0]   idx
);

    // Scan from the top index down, so the lowest qualifying index is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module adc_seq_ctrl
// Holds the start bits, the abort bits and the conversion state machine.
// Assumptions: the converter restarts when it gets a new start pulse, so a
// conversion that was abandoned never delivers a late done strobe once
// another start has been sent. Done strobes that arrive in ST_IDLE are
// dropped. Channel search results come from adc_seq_pick instances in
// the parent.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_en,
    input  logic            norm_go,
    input  logic            inj_go,
    input  logic            abort_conv_req,
    input  logic            abort_chain_req,
    input  logic            conv_done,
    input  logic            nf_found,
    input  logic [CH_W-1:0] nf_idx,
    input  logic            if_found,
    input  logic [CH_W-1:0] if_idx,
    input  logic            nx_found,
    input  logic [CH_W-1:0] nx_idx,
    output logic [CH_W-1:0] cur_ch,
    output logic            cur_inj,
    output logic            soc,
    output logic [CH_W-1:0] soc_ch,
    output logic            soc_inj,
    output logic            eoc_out,
    output logic [CH_W-1:0] eoc_ch,
    output logic            eoc_inj,
    output logic            norm_irq,
    output logic            inj_irq,
    output logic            norm_active,
    output logic            inj_active,
    output logic            abort_conv_pend,
    output logic            abort_chain_pend
);

    seq_st_e         st;
    logic [CH_W-1:0] nptr;      // normal channel to resume at
    logic            nptr_vld;  // nptr is valid; otherwise start at the lowest selected channel
    logic            finish;    // the current channel ends this cycle
    logic            good_done; // it ends with a real result
    logic [CH_W-1:0] norm_ch;   // channel a normal dispatch would start

    // A channel ends either when the converter reports done or when it is aborted.
    always_comb begin
        finish    = (st == ST_CONV) && (conv_done || abort_conv_pend);
        good_done = conv_done && !abort_conv_pend;
        norm_ch   = nptr_vld ? nptr : nf_idx;
    end

    // State machine: take requests, dispatch chains, step through channels, handle aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st               <= ST_IDLE;
            nptr             <= '0;
            nptr_vld         <= 1'b0;
            cur_ch           <= '0;
            cur_inj          <= TAG_NORM;
            soc              <= 1'b0;
            soc_ch           <= '0;
            soc_inj          <= TAG_NORM;
            eoc_out          <= 1'b0;
            eoc_ch           <= '0;
            eoc_inj          <= TAG_NORM;
            norm_irq         <= 1'b0;
            inj_irq          <= 1'b0;
            norm_active      <= 1'b0;
            inj_active       <= 1'b0;
            abort_conv_pend  <= 1'b0;
            abort_chain_pend <= 1'b0;
        end else begin
            soc      <= 1'b0;
            eoc_out  <= 1'b0;
            norm_irq <= 1'b0;
            inj_irq  <= 1'b0;

            // Requests are taken first; a clear further down in the same cycle overrides them.
            if (norm_go)
                norm_active <= 1'b1;
            if (inj_go)
                inj_active <= 1'b1;
            if (abort_conv_req && (st == ST_CONV))
                abort_conv_pend <= 1'b1;
            if (abort_chain_req && (norm_active || inj_active))
                abort_chain_pend <= 1'b1;

            if (abort_chain_pend) begin
                abort_chain_pend <= 1'b0;
                abort_conv_pend  <= 1'b0;
                st               <= ST_IDLE;
                if (inj_active) begin
                    inj_active  <= 1'b0;
                    norm_active <= 1'b0;
                    nptr_vld    <= 1'b0;
                end else if (scan_en) begin
                    nptr_vld <= 1'b0;
                end else begin
                    norm_active <= 1'b0;
                    nptr_vld    <= 1'b0;
                end
            end else if (st == ST_IDLE) begin
                abort_conv_pend <= 1'b0;
                if (inj_active) begin
                    if (!if_found) begin
                        inj_irq    <= 1'b1;
                        inj_active <= 1'b0;
                    end else begin
                        soc     <= 1'b1;
                        soc_ch  <= if_idx;
                        soc_inj <= TAG_INJ;
                        cur_ch  <= if_idx;
                        cur_inj <= TAG_INJ;
                        st      <= ST_CONV;
                    end
                end else if (norm_active) begin
                    if (!nptr_vld && !nf_found) begin
                        norm_irq    <= 1'b1;
                        norm_active <= 1'b0;
                    end else begin
                        soc     <= 1'b1;
                        soc_ch  <= norm_ch;
                        soc_inj <= TAG_NORM;
                        cur_ch  <= norm_ch;
                        cur_inj <= TAG_NORM;
                        st      <= ST_CONV;
                    end
                end
            end else if (finish) begin
                abort_conv_pend <= 1'b0;
                if (good_done) begin
                    eoc_out <= 1'b1;
                    eoc_ch  <= cur_ch;
                    eoc_inj <= cur_inj;
                end
                if (cur_inj == TAG_INJ) begin
                    if (nx_found) begin
                        soc     <= 1'b1;
                        soc_ch  <= nx_idx;
                        soc_inj <= TAG_INJ;
                        cur_ch  <= nx_idx;
                    end else begin
                        inj_irq    <= 1'b1;
                        inj_active <= 1'b0;
                        st         <= ST_IDLE;
                    end
                end else if (nx_found) begin
                    if (inj_active) begin
                        nptr     <= nx_idx;
                        nptr_vld <= 1'b1;
                        st       <= ST_IDLE;
                    end else begin
                        soc     <= 1'b1;
                        soc_ch  <= nx_idx;
                        soc_inj <= TAG_NORM;
                        cur_ch  <= nx_idx;
                    end
                end else begin
                    norm_irq <= 1'b1;
                    nptr_vld <= 1'b0;
                    st       <= ST_IDLE;
                    if (!scan_en)
                        norm_active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/adc_chain_seq.sv
// Module adc_chain_seq
// Top of the chain sequencer. Three channel pickers feed one controller:
// two find the lowest selected channel of each chain, and one finds the
// channel after the current one in the chain being converted.
// Assumes the masks stay stable while their chain is being dispatched.
module adc_chain_seq #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic [NUM_CH-1:0] norm_mask,
    input  logic [NUM_CH-1:0] inj_mask,
    input  logic              norm_go,
    input  logic              inj_go,
    input  logic              abort_conv_req,
    input  logic              abort_chain_req,
    input  logic              conv_done,
    output logic              soc,
    output logic [CH_W-1:0]   soc_ch,
    output logic              soc_inj,
    output logic              eoc_out,
    output logic [CH_W-1:0]   eoc_ch,
    output logic              eoc_inj,
    output logic              norm_irq,
    output logic              inj_irq,
    output logic              norm_active,
    output logic              inj_active,
    output logic              abort_conv_pend,
    output logic              abort_chain_pend
);

    logic [1:0][NUM_CH-1:0] masks;
    logic [1:0]             first_found;
    logic [1:0][CH_W-1:0]   first_idx;
    logic [NUM_CH-1:0]      nx_mask;
    logic [CH_W:0]          nx_from;
    logic                   nx_found;
    logic [CH_W-1:0]        nx_idx;
    logic [CH_W-1:0]        cur_ch;
    logic                   cur_inj;

    // Index 0 is the normal chain and index 1 the injected chain; the next-channel search follows the current chain.
    always_comb begin
        masks   = {inj_mask, norm_mask};
        nx_mask = cur_inj ? inj_mask : norm_mask;
        nx_from = {1'b0, cur_ch} + (CH_W + 1)'(1);
    end

    // One lowest-channel picker for each chain.
    for (genvar g = 0; g < 2; g++) begin : g_first
        adc_seq_pick #(.NUM_CH(NUM_CH)) u_first (
            .mask  (masks[g]),
            .from  ('0),
            .found (first_found[g]),
            .idx   (first_idx[g])
        );
    end

    adc_seq_pick #(.NUM_CH(NUM_CH)) u_next (
        .mask  (nx_mask),
        .from  (nx_from),
        .found (nx_found),
        .idx   (nx_idx)
    );

    adc_seq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .scan_en          (scan_en),
        .norm_go          (norm_go),
        .inj_go           (inj_go),
        .abort_conv_req   (abort_conv_req),
        .abort_chain_req  (abort_chain_req),
        .conv_done        (conv_done),
        .nf_found         (first_found[0]),
        .nf_idx           (first_idx[0]),
        .if_found         (first_found[1]),
        .if_idx           (first_idx[1]),
        .nx_found         (nx_found),
        .nx_idx           (nx_idx),
        .cur_ch           (cur_ch),
        .cur_inj          (cur_inj),
        .soc              (soc),
        .soc_ch           (soc_ch),
        .soc_inj          (soc_inj),
        .eoc_out          (eoc_out),
        .eoc_ch           (eoc_ch),
        .eoc_inj          (eoc_inj),
        .norm_irq         (norm_irq),
        .inj_irq          (inj_irq),
        .norm_active      (norm_active),
        .inj_active       (inj_active),
        .abort_conv_pend  (abort_conv_pend),
        .abort_chain_pend (abort_chain_pend)
    );

endmodule

// File: rtl/adc_chain_seq_chk.sv
// Module adc_chain_seq_chk
// Checks port-level timing rules of adc_chain_seq; attached with bind below.
module adc_chain_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic scan_en,
    input logic conv_done,
    input logic soc,
    input logic soc_inj,
    input logic eoc_out,
    input logic norm_irq,
    input logic inj_irq,
    input logic norm_active,
    input logic inj_active,
    input logic abort_conv_pend,
    input logic abort_chain_pend
);

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(norm_irq && inj_irq)); // R4
    AST_INJ_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) inj_irq |-> !inj_active); // R13
    AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (norm_irq && !$past(scan_en)) |-> !norm_active); // R4
    AST_ABORT_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) abort_conv_pend |=> !abort_conv_pend); // R9
    AST_ABORTED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) abort_conv_pend |=> !eoc_out); // R9
    AST_ABORT_CHAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) abort_chain_pend |=> !abort_chain_pend); // R10
    AST_CHAIN_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) abort_chain_pend |=> (!norm_irq && !inj_irq)); // R12
    AST_STROBE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) eoc_out |-> $past(conv_done)); // R3
    AST_SOC_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n) soc |-> (soc_inj ? inj_active : norm_active)); // R2

endmodule

bind adc_chain_seq adc_chain_seq_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .scan_en          (scan_en),
    .conv_done        (conv_done),
    .soc              (soc),
    .soc_inj          (soc_inj),
    .eoc_out          (eoc_out),
    .norm_irq         (norm_irq),
    .inj_irq          (inj_irq),
    .norm_active      (norm_active),
    .inj_active       (inj_active),
    .abort_conv_pend  (abort_conv_pend),
    .abort_chain_pend (abort_chain_pend)
);

// File: tb/adc_chain_seq_test.sv
// Module adc_conv_stub
// Converter model: done pulses LAT+1 cycles after a start; a new start restarts the count.
module adc_conv_stub #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    int cnt;

    // Count down from each start and pulse done when the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= 0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt <= LAT;
            end else if (cnt != 0) begin
                cnt  <= cnt - 1;
                done <= (cnt == 1);
            end
        end
    end
endmodule

// Module adc_chain_seq_test
// Directed bench: one task for each scenario, each comparing the logged strobes with the expected list.
module adc_chain_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int CW         = $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scan_en = 1'b0;
    logic [NUM_CH-1:0] norm_mask = '0;
    logic [NUM_CH-1:0] inj_mask = '0;
    logic              norm_go = 1'b0;
    logic              inj_go = 1'b0;
    logic              abort_conv_req = 1'b0;
    logic              abort_chain_req = 1'b0;
    logic              conv_done;
    logic              soc;
    logic [CW-1:0]     soc_ch;
    logic              soc_inj;
    logic              eoc_out;
    logic [CW-1:0]     eoc_ch;
    logic              eoc_inj;
    logic              norm_irq;
    logic              inj_irq;
    logic              norm_active;
    logic              inj_active;
    logic              abort_conv_pend;
    logic              abort_chain_pend;

    adc_chain_seq #(.NUM_CH(NUM_CH)) uut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
        .norm_mask(norm_mask), .inj_mask(inj_mask),
        .norm_go(norm_go), .inj_go(inj_go),
        .abort_conv_req(abort_conv_req), .abort_chain_req(abort_chain_req),
        .conv_done(conv_done),
        .soc(soc), .soc_ch(soc_ch), .soc_inj(soc_inj),
        .eoc_out(eoc_out), .eoc_ch(eoc_ch), .eoc_inj(eoc_inj),
        .norm_irq(norm_irq), .inj_irq(inj_irq),
        .norm_active(norm_active), .inj_active(inj_active),
        .abort_conv_pend(abort_conv_pend), .abort_chain_pend(abort_chain_pend)
    );

    adc_conv_stub #(.LAT(4)) u_stub (.clk(clk), .rst_n(rst_n), .start(soc), .done(conv_done));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int         n_checks = 0;
    int         n_fail = 0;
    logic [7:0] log_q [32];
    int         log_n = 0;
    int         nirq_n = 0;
    int         iirq_n = 0;
    int         soc_n = 0;
    logic [7:0] nirq_at = 8'hFF;
    logic [7:0] iirq_at = 8'hFF;

    function automatic logic [7:0] code(input logic inj, input int ch);
        return {inj, 7'(ch)};
    endfunction

    // Log result strobes, interrupts and start pulses at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (eoc_out && log_n < 32) begin
                log_q[log_n] = code(eoc_inj, int'(eoc_ch));
                log_n++;
            end
            if (norm_irq) begin
                nirq_n++;
                nirq_at = eoc_out ? code(eoc_inj, int'(eoc_ch)) : 8'hFF;
            end
            if (inj_irq) begin
                iirq_n++;
                iirq_at = eoc_out ? code(eoc_inj, int'(eoc_ch)) : 8'hFF;
            end
            if (soc) soc_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clr();
        log_n = 0; nirq_n = 0; iirq_n = 0; soc_n = 0;
        nirq_at = 8'hFF; iirq_at = 8'hFF;
    endtask

    // which: 0 normal start, 1 injected start, 2 channel abort, 3 chain abort
    task automatic pulse(input int which);
        step();
        case (which)
            0: norm_go = 1'b1;
            1: inj_go = 1'b1;
            2: abort_conv_req = 1'b1;
            default: abort_chain_req = 1'b1;
        endcase
        step();
        norm_go = 1'b0; inj_go = 1'b0; abort_conv_req = 1'b0; abort_chain_req = 1'b0;
    endtask

    task automatic wait_log(input int n, input string req);
        int t = 0;
        while (log_n < n && t < 500) begin
            step();
            t++;
        end
        if (log_n < n) chk(req, log_n, n);
    endtask

    task automatic entry(input string req, input int idx, input logic inj, input int ch);
        chk(req, int'(log_q[idx]), int'(code(inj, ch)));
    endtask

    task automatic t_reset();
        repeat (4) step();
        chk("R1 outputs in reset", int'({soc, eoc_out, norm_irq, inj_irq, norm_active, inj_active,
            abort_conv_pend, abort_chain_pend, soc_ch, eoc_ch, soc_inj, eoc_inj}), 0);
        rst_n = 1'b1;
        step();
        chk("R1 outputs after reset", int'({soc, eoc_out, norm_irq, inj_irq, norm_active, inj_active,
            abort_conv_pend, abort_chain_pend}), 0);
    endtask

    task automatic t_oneshot();
        scan_en = 1'b0; norm_mask = 8'b1010_0101; clr();
        pulse(0);
        wait_log(4, "R2 one-shot strobes");
        repeat (3) step();
        chk("R2 strobe count", log_n, 4);
        entry("R2 first", 0, 1'b0, 0);
        entry("R2 second", 1, 1'b0, 2);
        entry("R3 third", 2, 1'b0, 5);
        entry("R3 fourth", 3, 1'b0, 7);
        chk("R4 irq count", nirq_n, 1);
        chk("R4 irq with last strobe", int'(nirq_at), int'(code(1'b0, 7)));
        chk("R4 start bit cleared", int'(norm_active), 0);
        repeat (5) step();
    endtask

    task automatic t_scan();
        scan_en = 1'b1; norm_mask = 8'b0100_0010; clr();
        pulse(0);
        wait_log(5, "R5 scan strobes");
        chk("R5 start bit held", int'(norm_active), 1);
        entry("R5 e0", 0, 1'b0, 1);
        entry("R5 e1", 1, 1'b0, 6);
        entry("R5 e2", 2, 1'b0, 1);
        entry("R5 e3", 3, 1'b0, 6);
        entry("R5 e4", 4, 1'b0, 1);
        chk("R5 irq per pass", nirq_n, 2);
        scan_en = 1'b0;
        wait_log(6, "R5 last pass");
        repeat (3) step();
        chk("R5 stops after scan off", log_n, 6);
        chk("R4 start bit cleared after scan off", int'(norm_active), 0);
        repeat (5) step();
    endtask

    task automatic t_inj_empty();
        inj_mask = '0; clr();
        pulse(1);
        repeat (2) step();
        chk("R6 inj irq", iirq_n, 1);
        chk("R6 no start pulse", soc_n, 0);
        chk("R6 inj bit cleared", int'(inj_active), 0);
        repeat (3) step();
    endtask

    task automatic t_suspend();
        scan_en = 1'b0; norm_mask = 8'h0F; inj_mask = 8'b0101_0000; clr();
        pulse(0);
        wait_log(1, "R7 first normal");
        pulse(1);
        wait_log(6, "R7 strobes");
        repeat (3) step();
        chk("R7 strobe count", log_n, 6);
        entry("R7 e0", 0, 1'b0, 0);
        entry("R7 e1", 1, 1'b0, 1);
        entry("R3 injected tag e2", 2, 1'b1, 4);
        entry("R3 injected tag e3", 3, 1'b1, 6);
        entry("R7 resume e4", 4, 1'b0, 2);
        entry("R7 resume e5", 5, 1'b0, 3);
        chk("R13 inj irq with last injected strobe", int'(iirq_at), int'(code(1'b1, 6)));
        chk("R13 inj irq count", iirq_n, 1);
        chk("R13 inj bit cleared", int'(inj_active), 0);
        chk("R4 normal done", int'(norm_active), 0);
        repeat (5) step();
    endtask

    task automatic t_inj_repeat();
        norm_mask = '0; inj_mask = 8'b0000_1100; clr();
        pulse(1);
        wait_log(1, "R8 first injected");
        pulse(1);
        repeat (15) step();
        chk("R8 chain ran once", log_n, 2);
        entry("R8 e0", 0, 1'b1, 2);
        entry("R8 e1", 1, 1'b1, 3);
        chk("R8 single irq", iirq_n, 1);
        chk("R8 inj bit cleared", int'(inj_active), 0);
    endtask

    task automatic t_abort_conv();
        scan_en = 1'b0; norm_mask = 8'b0001_1010; clr();
        pulse(0);
        wait_log(1, "R9 first strobe");
        step();
        abort_conv_req = 1'b1;
        step();
        abort_conv_req = 1'b0;
        chk("R9 abort bit set", int'(abort_conv_pend), 1);
        chk("R9 start bit held", int'(norm_active), 1);
        step();
        chk("R9 abort bit cleared at next start", int'(abort_conv_pend), 0);
        chk("R9 restart pulse", int'(soc), 1);
        chk("R9 restart channel", int'(soc_ch), 4);
        wait_log(2, "R9 strobes");
        repeat (3) step();
        chk("R9 aborted channel has no strobe", log_n, 2);
        entry("R9 e0", 0, 1'b0, 1);
        entry("R9 e1", 1, 1'b0, 4);
        chk("R9 chain still ends", nirq_n, 1);
        repeat (5) step();
    endtask

    task automatic t_chain_oneshot();
        scan_en = 1'b0; norm_mask = 8'h0F; clr();
        pulse(0);
        wait_log(1, "R10 first strobe");
        pulse(3);
        repeat (15) step();
        chk("R10 no more strobes", log_n, 1);
        chk("R10 no irq", nirq_n, 0);
        chk("R10 start bit cleared", int'(norm_active), 0);
        chk("R10 abort bit cleared", int'(abort_chain_pend), 0);
    endtask

    task automatic t_chain_scan();
        scan_en = 1'b1; norm_mask = 8'b0010_0100; clr();
        pulse(0);
        wait_log(1, "R11 first strobe");
        pulse(3);
        wait_log(2, "R11 restart strobe");
        entry("R11 e0", 0, 1'b0, 2);
        entry("R11 restarted at lowest", 1, 1'b0, 2);
        chk("R11 no irq", nirq_n, 0);
        chk("R11 start bit held", int'(norm_active), 1);
        scan_en = 1'b0;
        pulse(3);
        repeat (15) step();
        chk("R10 stopped", int'(norm_active), 0);
    endtask

    task automatic t_abort_both();
        scan_en = 1'b0; norm_mask = 8'h0F; inj_mask = 8'b1110_0000; clr();
        pulse(0);
        wait_log(1, "R12 first normal");
        pulse(1);
        wait_log(3, "R12 first injected");
        pulse(3);
        repeat (15) step();
        chk("R12 strobe count", log_n, 3);
        entry("R12 e2", 2, 1'b1, 5);
        chk("R12 inj bit cleared", int'(inj_active), 0);
        chk("R12 normal bit cleared", int'(norm_active), 0);
        chk("R12 no irq", nirq_n + iirq_n, 0);
    endtask

    initial begin
        t_reset();
        t_oneshot();
        t_scan();
        t_inj_empty();
        t_suspend();
        t_inj_repeat();
        t_abort_conv();
        t_chain_oneshot();
        t_chain_scan();
        t_abort_both();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule